// File: doc/BRIEF.md
# Bus-Size-Aware Mailbox Register Pair

This block gives three ports a side channel that bypasses the data queues. A wide port A posts a message for a narrower port B. Port B sees the message and takes it. In the other direction, port C posts a message that port A takes. Each direction has one mailbox register and a full flag. The flag rises when a message is posted and falls when the reader takes it. While the flag is up, further posts to that mailbox are refused, so an unread message is never overwritten. Reading a mailbox does not change what it holds. Only a new accepted post changes it.

Ports B and C each have a static bus-size select that chooses a 9-bit byte bus or an 18-bit word bus. That choice decides which bit lanes carry mail:
- Port B receives A's low lanes on its own low lanes.
- Port C's low lanes land on the upper half of port A.

Output lanes outside the active set carry a fill value, which is X for simulation or zero for synthesis. Input lanes outside the active set are ignored. The size selects are captured while reset is asserted and hold until the next reset. Port A, port B and port C share one clock.

Top module: `mbx_pair`

## Requirements
- R1: A post to an empty mailbox (`a_mb_wr` for the A-to-B mailbox, `c_mb_wr` for the C-to-A mailbox) stores the data and raises that mailbox's full flag on the first rising edge after the strobe.
- R2: A read strobe (`b_mb_rd` or `a_mb_rd`) loads that reader's output register with the mailbox contents and clears the full flag, both visible after the same edge. The contents stay intact, so a second read returns the same value.
- R3: A post to a mailbox whose full flag is set is refused, and the stored message is unchanged.
- R4: With port B in word mode (size select = 1), `b_dout[17:0]` carries `a_din[17:0]`. In byte mode (size select = 0), `b_dout[8:0]` carries `a_din[8:0]` and `b_dout[17:9]` carries the fill value.
- R5: With port C in word mode, `a_dout[35:18]` carries `c_din[17:0]`. In byte mode, `a_dout[26:18]` carries `c_din[8:0]`, `a_dout[35:27]` carries the fill value, and `c_din[17:9]` is ignored.
- R6: `a_dout[17:0]` never carries mail and always holds the fill value.
- R7: The fill value is all zero when `FILL_X` = 0 and all X when `FILL_X` = 1.
- R8: A synchronous active-high reset clears both full flags, both mailboxes and both output registers. Strobes seen while reset is high have no effect.
- R9: The size selects are sampled while reset is high. A change after reset has no effect until the next reset.
- R10: If a read and a post arrive in the same cycle, the read returns the old contents. The post is accepted and the flag ends set if the mailbox was empty. The post is refused and the flag ends clear if the mailbox was full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for all three ports |
| rst | input | 1 | Synchronous active-high reset; also samples the size selects |
| size_b | input | 1 | Port B bus size: 1 word (18 bits), 0 byte (9 bits) |
| size_c | input | 1 | Port C bus size: 1 word (18 bits), 0 byte (9 bits) |
| a_din | input | 18 | Port A mail lanes written toward port B |
| a_mb_wr | input | 1 | Port A post strobe into the A-to-B mailbox |
| a_mb_rd | input | 1 | Port A read strobe from the C-to-A mailbox |
| a_dout | output | 36 | Port A registered mail output (upper half mail, lower half fill) |
| a_mail_full | output | 1 | C-to-A mailbox holds an unread message |
| b_mb_rd | input | 1 | Port B read strobe from the A-to-B mailbox |
| b_dout | output | 18 | Port B registered mail output |
| b_mail_full | output | 1 | A-to-B mailbox holds an unread message |
| c_din | input | 18 | Port C mail lanes written toward port A |
| c_mb_wr | input | 1 | Port C post strobe into the C-to-A mailbox |

## Verification
Every result in this block arrives one edge after its strobe:
- A post raises the flag at the first rising edge after the strobe.
- A read updates the output register and drops the flag at that same edge.

The bench drives each stimulus at a falling edge and lets exactly one rising edge pass. It then samples at the following falling edge, so each check reads the state one register stage behind the stimulus. Size selects only take effect through a reset, so each size mode is set up by a reset sequence before its checks, and the check after a size change without reset confirms the old lane map still holds.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    BUS_BYTE = 1'b0,
    BUS_WORD = 1'b1
  } bus_size_e;
endpackage

// File: rtl/mbx_cfg.sv
// Captures a bus-size select while reset is high and holds it afterwards.
module mbx_cfg
  import mbx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      size_in,
  output bus_size_e size_q
);
  always_ff @(posedge clk) begin
    if (rst) size_q <= bus_size_e'(size_in);
  end
endmodule

// File: rtl/mbx_slot.sv
// One mailbox register with its full flag. A post is refused while full.
module mbx_slot #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic         rd,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] data
);
  logic take;
  assign take = wr && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (take) data <= din;
      if (take)    full <= 1'b1;
      else if (rd) full <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_lane.sv
// Reader-side output register: active lanes carry mail, others carry fill.
module mbx_lane
  import mbx_pkg::*;
#(
  parameter int W      = 18,
  parameter int BYTE_W = 9,
  parameter bit FILL_X = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  bus_size_e    size,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] BYTE_MASK = {{(W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [W-1:0] FILL      = FILL_X ? {W{1'bx}} : {W{1'b0}};

  logic [W-1:0] mask;
  assign mask = (size == BUS_WORD) ? {W{1'b1}} : BYTE_MASK;

  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (ld) dout <= (din & mask) | (FILL & ~mask);
  end
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int A_W    = 36,
  parameter int N_W    = 18,
  parameter int BYTE_W = 9,
  parameter bit FILL_X = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           size_b,
  input  logic           size_c,
  input  logic [N_W-1:0] a_din,
  input  logic           a_mb_wr,
  input  logic           a_mb_rd,
  output logic [A_W-1:0] a_dout,
  output logic           a_mail_full,
  input  logic           b_mb_rd,
  output logic [N_W-1:0] b_dout,
  output logic           b_mail_full,
  input  logic [N_W-1:0] c_din,
  input  logic           c_mb_wr
);
  localparam int LOW_W = A_W - N_W;
  localparam logic [N_W-1:0]   BYTE_MASK = {{(N_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [LOW_W-1:0] LOW_FILL  = FILL_X ? {LOW_W{1'bx}} : {LOW_W{1'b0}};

  bus_size_e    sz_b_q, sz_c_q;
  logic [N_W-1:0] ab_in, ca_in, ab_data, ca_data, a_hi;

  mbx_cfg u_cfg_b (.clk(clk), .rst(rst), .size_in(size_b), .size_q(sz_b_q));
  mbx_cfg u_cfg_c (.clk(clk), .rst(rst), .size_in(size_c), .size_q(sz_c_q));

  // Lanes outside the active bus never reach the stored message.
  assign ab_in = a_din & ((sz_b_q == BUS_WORD) ? {N_W{1'b1}} : BYTE_MASK);
  assign ca_in = c_din & ((sz_c_q == BUS_WORD) ? {N_W{1'b1}} : BYTE_MASK);

  mbx_slot #(.W(N_W)) u_slot_ab (
    .clk(clk), .rst(rst), .wr(a_mb_wr), .rd(b_mb_rd),
    .din(ab_in), .full(b_mail_full), .data(ab_data)
  );

  mbx_slot #(.W(N_W)) u_slot_ca (
    .clk(clk), .rst(rst), .wr(c_mb_wr), .rd(a_mb_rd),
    .din(ca_in), .full(a_mail_full), .data(ca_data)
  );

  mbx_lane #(.W(N_W), .BYTE_W(BYTE_W), .FILL_X(FILL_X)) u_lane_b (
    .clk(clk), .rst(rst), .ld(b_mb_rd), .size(sz_b_q),
    .din(ab_data), .dout(b_dout)
  );

  mbx_lane #(.W(N_W), .BYTE_W(BYTE_W), .FILL_X(FILL_X)) u_lane_a (
    .clk(clk), .rst(rst), .ld(a_mb_rd), .size(sz_c_q),
    .din(ca_data), .dout(a_hi)
  );

  // Mail from port C lands on the upper lanes of port A.
  assign a_dout = {a_hi, LOW_FILL};
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk
  import mbx_pkg::*;
#(
  parameter int A_W    = 36,
  parameter int N_W    = 18,
  parameter int BYTE_W = 9,
  parameter bit FILL_X = 1'b0
) (
  input logic           clk,
  input logic           rst,
  input logic           a_mb_wr,
  input logic           a_mb_rd,
  input logic           b_mb_rd,
  input logic           c_mb_wr,
  input logic           a_mail_full,
  input logic           b_mail_full,
  input logic [A_W-1:0] a_dout,
  input logic [N_W-1:0] b_dout,
  input logic [N_W-1:0] ab_data,
  input logic [N_W-1:0] ca_data,
  input bus_size_e      sz_b_q,
  input bus_size_e      sz_c_q
);
  // R1
  a_r1_post_sets_b: assert property (@(posedge clk) disable iff (rst)
    (a_mb_wr && !b_mail_full) |=> b_mail_full);
  a_r1_post_sets_a: assert property (@(posedge clk) disable iff (rst)
    (c_mb_wr && !a_mail_full) |=> a_mail_full);
  // R2
  a_r2_read_clears_b: assert property (@(posedge clk) disable iff (rst)
    (b_mb_rd && b_mail_full) |=> !b_mail_full);
  a_r2_hold_b: assert property (@(posedge clk) disable iff (rst)
    !b_mb_rd |=> $stable(b_dout));
  a_r2_hold_a: assert property (@(posedge clk) disable iff (rst)
    !a_mb_rd |=> $stable(a_dout));
  // R3
  a_r3_no_overwrite_ab: assert property (@(posedge clk) disable iff (rst)
    b_mail_full |=> $stable(ab_data));
  a_r3_no_overwrite_ca: assert property (@(posedge clk) disable iff (rst)
    a_mail_full |=> $stable(ca_data));
  // R4, R7
  a_r4_b_fill: assert property (@(posedge clk) disable iff (rst)
    (!FILL_X && sz_b_q == BUS_BYTE) |-> (b_dout[N_W-1:BYTE_W] == '0));
  // R5, R7
  a_r5_a_fill: assert property (@(posedge clk) disable iff (rst)
    (!FILL_X && sz_c_q == BUS_BYTE) |-> (a_dout[A_W-1:A_W-N_W+BYTE_W] == '0));
  // R6
  a_r6_low_fill: assert property (@(posedge clk) disable iff (rst)
    !FILL_X |-> (a_dout[A_W-N_W-1:0] == '0));
  // R8
  a_r8_reset_flags: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!a_mail_full && !b_mail_full));
  // R9
  a_r9_size_static: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(sz_b_q) && $stable(sz_c_q)));
endmodule

bind mbx_pair mbx_pair_chk #(.A_W(A_W), .N_W(N_W), .BYTE_W(BYTE_W), .FILL_X(FILL_X)) u_chk (
  .clk(clk), .rst(rst), .a_mb_wr(a_mb_wr), .a_mb_rd(a_mb_rd), .b_mb_rd(b_mb_rd),
  .c_mb_wr(c_mb_wr), .a_mail_full(a_mail_full), .b_mail_full(b_mail_full),
  .a_dout(a_dout), .b_dout(b_dout), .ab_data(ab_data), .ca_data(ca_data),
  .sz_b_q(sz_b_q), .sz_c_q(sz_c_q)
);

// File: tb/test_mbx_pair.sv
module test_mbx_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        size_b = 1'b1, size_c = 1'b1;
  logic [17:0] a_din = '0, c_din = '0;
  logic        a_mb_wr = 0, a_mb_rd = 0, b_mb_rd = 0, c_mb_wr = 0;
  logic [35:0] a_dout;
  logic [17:0] b_dout;
  logic        a_mail_full, b_mail_full;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_pair i_mbx_pair (
    .clk(clk), .rst(rst), .size_b(size_b), .size_c(size_c),
    .a_din(a_din), .a_mb_wr(a_mb_wr), .a_mb_rd(a_mb_rd), .a_dout(a_dout),
    .a_mail_full(a_mail_full), .b_mb_rd(b_mb_rd), .b_dout(b_dout),
    .b_mail_full(b_mail_full), .c_din(c_din), .c_mb_wr(c_mb_wr)
  );

  typedef struct packed {
    logic        aw;
    logic [17:0] ad;
    logic        br;
    logic        cw;
    logic [17:0] cd;
    logic        ar;
    logic        eb_full;
    logic        ea_full;
    logic [17:0] ebd;
    logic [35:0] ead;
  } vec_t;

  localparam int NV = 12;
  // Word mode on both narrow ports; each row is one cycle.
  localparam vec_t TBL [NV] = '{
    '{1, 18'h2ABCD, 0, 0, 18'h0,     0, 1, 0, 18'h0,     36'h0},               // R1
    '{1, 18'h11111, 0, 0, 18'h0,     0, 1, 0, 18'h0,     36'h0},               // R3
    '{0, 18'h0,     1, 0, 18'h0,     0, 0, 0, 18'h2ABCD, 36'h0},               // R2 R4
    '{0, 18'h0,     1, 0, 18'h0,     0, 0, 0, 18'h2ABCD, 36'h0},               // R2
    '{0, 18'h0,     0, 1, 18'h3C3C3, 0, 0, 1, 18'h2ABCD, 36'h0},               // R1
    '{0, 18'h0,     0, 1, 18'h00001, 0, 0, 1, 18'h2ABCD, 36'h0},               // R3
    '{0, 18'h0,     0, 0, 18'h0,     1, 0, 0, 18'h2ABCD, {18'h3C3C3, 18'h0}},  // R2 R5 R6
    '{1, 18'h00155, 1, 0, 18'h0,     0, 1, 0, 18'h2ABCD, {18'h3C3C3, 18'h0}},  // R10
    '{1, 18'h3FFFF, 1, 0, 18'h0,     0, 0, 0, 18'h00155, {18'h3C3C3, 18'h0}},  // R10
    '{0, 18'h0,     1, 0, 18'h0,     0, 0, 0, 18'h00155, {18'h3C3C3, 18'h0}},  // R3 R10
    '{0, 18'h0,     0, 1, 18'h12345, 1, 0, 1, 18'h00155, {18'h3C3C3, 18'h0}},  // R10
    '{0, 18'h0,     0, 0, 18'h0,     1, 0, 0, 18'h00155, {18'h12345, 18'h0}}   // R10
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at next falling edge.
  task automatic cyc(input logic aw, input logic [17:0] ad, input logic br,
                     input logic cw, input logic [17:0] cd, input logic ar);
    a_mb_wr = aw; a_din = ad; b_mb_rd = br; c_mb_wr = cw; c_din = cd; a_mb_rd = ar;
    @(posedge clk);
    @(negedge clk);
    a_mb_wr = 0; b_mb_rd = 0; c_mb_wr = 0; a_mb_rd = 0;
  endtask

  task automatic do_reset(input logic sb, input logic sc);
    rst = 1; size_b = sb; size_c = sc;
    c_mb_wr = 1;  // port C post strobe held high through reset
    a_mb_wr = 1; a_din = 18'h3FFFF;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0; c_mb_wr = 0; a_mb_wr = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset(1'b1, 1'b1);
    chk("R8 b_full", {35'h0, b_mail_full}, 36'h0);
    chk("R8 a_full", {35'h0, a_mail_full}, 36'h0);
    chk("R8 b_dout", {18'h0, b_dout}, 36'h0);
    chk("R8 a_dout", a_dout, 36'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].aw, TBL[i].ad, TBL[i].br, TBL[i].cw, TBL[i].cd, TBL[i].ar);
      chk("R1/R2/R3/R10 b_full", {35'h0, b_mail_full}, {35'h0, TBL[i].eb_full});
      chk("R1/R2/R3/R10 a_full", {35'h0, a_mail_full}, {35'h0, TBL[i].ea_full});
      chk("R2/R4 b_dout", {18'h0, b_dout}, {18'h0, TBL[i].ebd});
      chk("R2/R5/R6 a_dout", a_dout, TBL[i].ead);
    end

    // Byte mode on both narrow ports.
    do_reset(1'b0, 1'b0);
    chk("R8 strobes in reset b_full", {35'h0, b_mail_full}, 36'h0);
    chk("R8 strobes in reset a_full", {35'h0, a_mail_full}, 36'h0);
    cyc(1, 18'h3FFFF, 0, 1, 18'h3FFFF, 0);
    cyc(0, 18'h0, 1, 0, 18'h0, 1);
    chk("R4 byte lanes b", {18'h0, b_dout}, {18'h0, 18'h001FF});
    chk("R5 byte lanes a", a_dout, {9'h0, 9'h1FF, 18'h0});
    chk("R7 zero fill low a", {18'h0, a_dout[17:0]}, 36'h0);

    // R9: size change without reset keeps byte lanes.
    size_b = 1'b1; size_c = 1'b1;
    cyc(1, 18'h2AAAA, 0, 1, 18'h15555, 0);
    cyc(0, 18'h0, 1, 0, 18'h0, 1);
    chk("R9 size held b", {18'h0, b_dout}, {18'h0, 18'h000AA});
    chk("R9 size held a", a_dout, {9'h0, 9'h155, 18'h0});

    // R8: reset clears a pending message.
    cyc(1, 18'h00077, 0, 0, 18'h0, 0);
    chk("R1 pending", {35'h0, b_mail_full}, 36'h1);
    do_reset(1'b1, 1'b1);
    cyc(0, 18'h0, 1, 0, 18'h0, 0);
    chk("R8 content cleared", {18'h0, b_dout}, 36'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule